// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Start-Bit Validation

This block receives asynchronous serial characters on a single input line that idles high. A one-cycle enable running at sixteen times the bit rate paces all sampling. The line first passes through a synchronizer. A high-to-low transition out of idle starts a candidate character. The receiver waits about half a bit and samples the line again. The character is accepted only if the line is still low at that point, so short low glitches are ignored.

After a valid start bit, every data bit, the optional parity bit and the first stop bit are each sampled once, sixteen enable ticks apart. Data bits arrive least significant first. The completed character goes into a buffer register for the host. A four-bit status word reports the following:
- data waiting
- a lost character (overrun)
- bad parity
- a missing stop bit (framing error)

The host clears the data-waiting bit by reading the buffer. It clears the three error bits by reading the status.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_data` is 0 and `status` is 0.
- R2: A falling edge on `rx_in` starts a character only if the line is still low at the sample taken 8 ticks after the edge is detected. A low pulse shorter than that leaves `status` and `rx_data` unchanged.
- R3: `word_len` selects the number of data bits: 0 selects 5, 1 selects 6, 2 selects 7 and 3 selects 8. Bits are received least significant first. The result is right-aligned in `rx_data`, and the unused upper bits read 0.
- R4: When a character is transferred to the buffer, `status[0]` (data ready) is set. A one-cycle `rd_data` pulse clears it.
- R5: If a character is transferred while `status[0]` is still set, `status[1]` (overrun) is set, and `rx_data` takes the new character.
- R6: With `par_en` = 1, one parity bit follows the last data bit. With `par_even` = 1, the data bits and the parity bit must contain an even number of ones; with `par_even` = 0, an odd number. A mismatch sets `status[2]`.
- R7: If the first stop bit is sampled low, `status[3]` (framing error) is set. The character is still delivered. A new character starts only after the line has gone high again and then fallen.
- R8: `status[3:1]` are sticky. A `rd_stat` pulse clears them and leaves `status[0]` unchanged.
- R9: With `par_en` = 0, no parity bit is expected: the stop bit directly follows the last data bit, and `status[2]` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | One-cycle enable at 16x the bit rate |
| rx_in | input | 1 | Serial input line, idles high |
| word_len | input | 2 | Data bit count code (0..3 gives 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 selects even parity, 0 selects odd |
| rd_data | input | 1 | Host read of the buffer; clears data ready |
| rd_stat | input | 1 | Host read of the status; clears the error bits |
| rx_data | output | 8 | Last received character, right-aligned |
| status | output | 4 | {framing, parity, overrun, ready} |

## Verification
An edge on `rx_in` reaches the receiver 2 to 3 clocks later, after the synchronizer. The start-bit check happens on the 8th tick after that. The stop bit is sampled 16 ticks after each earlier cell, so `status` and `rx_data` change on the clock edge of the stop-cell tick, roughly half a bit into the stop cell. The bench drives each cell for a full bit time of 64 clocks. It reads results only at the end of the stop cell, well after that edge. A host read takes effect on the next clock edge, so those checks sample at the falling edge one clock after the pulse. The glitch test keeps the line low for only 3 ticks. It then waits two full bit times before confirming that nothing was received.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SRX_DMAX = 8;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [SRX_DMAX-1:0] data;
    logic                perr;
    logic                ferr;
  } rx_result_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign q    = chain_q[STAGES-1];
  assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic       fall,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  output logic       xfer,
  output rx_result_t res
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e             state_q, state_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic [2:0]            bit_q, bit_d;
  logic [SRX_DMAX-1:0]   sh_q, sh_d;
  logic                  par_q, par_d;
  logic                  perr_q, perr_d;
  logic [3:0]            nbits;
  logic                  sample;

  assign nbits  = 4'd5 + {2'b00, word_len};
  assign sample = tick && (cnt_q == ((state_q == RX_START) ? MID : LAST));

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    par_d    = par_q;
    perr_d   = perr_q;
    xfer     = 1'b0;
    res.data = sh_q >> (4'(SRX_DMAX) - nbits);
    res.perr = perr_q;
    res.ferr = ~line;
    if (state_q == RX_IDLE) begin
      if (fall) begin
        state_d = RX_START;
        cnt_d   = '0;
      end
    end else if (tick) begin
      cnt_d = sample ? '0 : cnt_q + 1'b1;
      if (sample) begin
        unique case (state_q)
          RX_START: begin
            if (!line) begin
              state_d = RX_DATA;
              bit_d   = '0;
              par_d   = 1'b0;
              perr_d  = 1'b0;
            end else begin
              state_d = RX_IDLE;
            end
          end
          RX_DATA: begin
            sh_d  = {line, sh_q[SRX_DMAX-1:1]};
            par_d = par_q ^ line;
            if ({1'b0, bit_q} == nbits - 4'd1)
              state_d = par_en ? RX_PAR : RX_STOP;
            else
              bit_d = bit_q + 3'd1;
          end
          RX_PAR: begin
            perr_d  = line ^ (par_even ? par_q : ~par_q);
            state_d = RX_STOP;
          end
          RX_STOP: begin
            xfer    = 1'b1;
            state_d = RX_IDLE;
          end
          default: state_d = RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      perr_q  <= perr_d;
    end
  end

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_DATA && $past(state_q) == RX_START) |-> $past(tick && !line));

  // R7
  idle_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> state_q == RX_IDLE);
endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xfer,
  input  rx_result_t          res,
  input  logic                rd_data,
  input  logic                rd_stat,
  output logic [SRX_DMAX-1:0] rx_data,
  output logic [3:0]          status
);
  logic [SRX_DMAX-1:0] buf_q, buf_d;
  logic                rdy_q, rdy_d;
  logic                ovr_q, ovr_d;
  logic                pe_q, pe_d;
  logic                fe_q, fe_d;

  always_comb begin
    buf_d = buf_q;
    rdy_d = rdy_q & ~rd_data;
    ovr_d = ovr_q & ~rd_stat;
    pe_d  = pe_q  & ~rd_stat;
    fe_d  = fe_q  & ~rd_stat;
    if (xfer) begin
      buf_d = res.data;
      rdy_d = 1'b1;
      if (rdy_q && !rd_data) ovr_d = 1'b1;
      if (res.perr) pe_d = 1'b1;
      if (res.ferr) fe_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
      pe_q  <= 1'b0;
      fe_q  <= 1'b0;
    end else begin
      buf_q <= buf_d;
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
      pe_q  <= pe_d;
      fe_q  <= fe_d;
    end
  end

  assign rx_data = buf_q;
  assign status  = {fe_q, pe_q, ovr_q, rdy_q};

  // R4
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> status[0]);

  // R4
  ready_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !xfer) |=> !status[0]);

  // R5
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && status[0] && !rd_data) |=> status[1]);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !rd_stat) |=> $stable(status[3:1]));
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_16x,
  input  logic       rx_in,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       rd_data,
  input  logic       rd_stat,
  output logic [7:0] rx_data,
  output logic [3:0] status
);
  logic       line_s;
  logic       fall_s;
  logic       xfer;
  rx_result_t res;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_in), .q(line_s), .fall(fall_s)
  );

  srx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x), .line(line_s), .fall(fall_s),
    .word_len(word_len), .par_en(par_en), .par_even(par_even),
    .xfer(xfer), .res(res)
  );

  srx_status u_status (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .res(res),
    .rd_data(rd_data), .rd_stat(rd_stat),
    .rx_data(rx_data), .status(status)
  );
endmodule

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb_top;
  localparam int BIT_CLK = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_16x;
  logic       rx_in = 1'b1;
  logic [1:0] word_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_even = 1'b1;
  logic       rd_data = 1'b0;
  logic       rd_stat = 1'b0;
  logic [7:0] rx_data;
  logic [3:0] status;
  logic [1:0] tdiv;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tdiv <= '0;
    else        tdiv <= tdiv + 2'd1;
  assign tick_16x = (tdiv == 2'd3);

  serial_rx_core dut_i (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .rx_in(rx_in),
    .word_len(word_len), .par_en(par_en), .par_even(par_even),
    .rd_data(rd_data), .rd_stat(rd_stat), .rx_data(rx_data), .status(status)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v);
    rx_in = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic pulse_rd(input bit d, input bit s);
    rd_data = d;
    rd_stat = s;
    @(negedge clk);
    rd_data = 1'b0;
    rd_stat = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit pen, input bit pev,
                      input bit flip_par, input bit bad_stop);
    logic p;
    word_len = 2'(nb - 5);
    par_en   = pen;
    par_even = pev;
    p = 1'b0;
    hold(1'b1);
    hold(1'b0);
    for (int i = 0; i < nb; i++) begin
      p = p ^ d[i];
      hold(d[i]);
    end
    if (pen) hold((pev ? p : ~p) ^ flip_par);
    hold(~bad_stop);
    rx_in = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 data", rx_data, 0);
    chk("R1 status", status, 0);
  endtask

  task automatic t_basic;
    send(8'hA5, 8, 0, 1, 0, 0);
    chk("R4 R9 data", rx_data, 8'hA5);
    chk("R4 R9 status", status, 4'b0001);
    pulse_rd(1, 0);
    chk("R4 cleared", status, 4'b0000);
  endtask

  task automatic t_len;
    send(8'hF3, 5, 0, 1, 0, 0);
    chk("R3 5 bits", rx_data, 8'h13);
    pulse_rd(1, 0);
    send(8'hEC, 6, 0, 1, 0, 0);
    chk("R3 6 bits", rx_data, 8'h2C);
    pulse_rd(1, 0);
    send(8'hD5, 7, 0, 1, 0, 0);
    chk("R3 7 bits", rx_data, 8'h55);
    chk("R3 status", status, 4'b0001);
    pulse_rd(1, 0);
  endtask

  task automatic t_noise;
    rx_in = 1'b0;
    repeat (12) @(negedge clk);
    rx_in = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    chk("R2 glitch status", status, 4'b0000);
    chk("R2 glitch data", rx_data, 8'h55);
  endtask

  task automatic t_overrun;
    send(8'h11, 8, 0, 1, 0, 0);
    send(8'h22, 8, 0, 1, 0, 0);
    chk("R5 status", status, 4'b0011);
    chk("R5 data", rx_data, 8'h22);
    pulse_rd(0, 1);
    chk("R8 stat read", status, 4'b0001);
    pulse_rd(1, 0);
    chk("R4 after overrun", status, 4'b0000);
  endtask

  task automatic t_parity;
    send(8'h37, 8, 1, 1, 0, 0);
    chk("R6 even ok", status, 4'b0001);
    chk("R6 even data", rx_data, 8'h37);
    pulse_rd(1, 0);
    send(8'h37, 8, 1, 1, 1, 0);
    chk("R6 even bad", status, 4'b0101);
    pulse_rd(1, 1);
    send(8'h4B, 7, 1, 0, 0, 0);
    chk("R6 odd ok", status, 4'b0001);
    pulse_rd(1, 0);
    send(8'h4B, 7, 1, 0, 1, 0);
    chk("R6 odd bad", status, 4'b0101);
    pulse_rd(1, 0);
    chk("R8 sticky perr", status, 4'b0100);
    pulse_rd(0, 1);
    chk("R8 cleared", status, 4'b0000);
  endtask

  task automatic t_frame;
    send(8'h5A, 8, 0, 1, 0, 1);
    chk("R7 ferr", status, 4'b1001);
    chk("R7 data", rx_data, 8'h5A);
    pulse_rd(1, 1);
    send(8'hC3, 8, 0, 1, 0, 0);
    chk("R7 recover", rx_data, 8'hC3);
    chk("R7 recover status", status, 4'b0001);
    pulse_rd(1, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_basic();
    t_len();
    t_noise();
    t_overrun();
    t_parity();
    t_frame();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule